// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address for a four-beat burst on a synchronous burst memory. A load strobe captures a full start address. Each later advance strobe moves the sequencer one beat forward. Only the low two address bits move during a burst. The bits above them keep the value captured at the load.

Two beat orderings are available at run time. In interleaved order, the low bits are the start bits XORed with the beat number. In linear order, the low bits count up modulo four from the start bits. The ordering is chosen by a mode input. Its value is captured together with the start address, and that captured value governs the whole burst. A flag marks the fourth beat, so the memory controller knows when the burst is complete.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addr_o` is all zeros and `last_o` is low.
- R2: In the cycle after `load_i` is sampled high, `addr_o` equals the `load_addr_i` value sampled at that edge, and `last_o` is low.
- R3: If `mode_i` was 1 at the load (interleaved), then after k advances the low two bits of `addr_o` equal the start low bits XOR (k mod 4).
- R4: If `mode_i` was 0 at the load (linear), then after k advances the low two bits of `addr_o` equal (start low bits + k) mod 4.
- R5: When `load_i` is low, bits above bit 1 of `addr_o` keep their value from the previous cycle.
- R6: A change of `mode_i` between loads has no effect on the ordering of the burst in progress.
- R7: When `load_i` and `adv_i` are both high at the same edge, the load wins. The next `addr_o` is the new start address and the beat count restarts at zero.
- R8: `last_o` is high exactly when the beat count is 3, which is the fourth beat of a burst.
- R9: An advance taken on the fourth beat returns `addr_o` to the start address of the burst.
- R10: When both `load_i` and `adv_i` are low, `addr_o` and `last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a burst at `load_addr_i` |
| load_addr_i | input | ADDR_W | Full start address |
| adv_i | input | 1 | Advance one beat |
| mode_i | input | 1 | Ordering: 1 interleaved, 0 linear; sampled at load |
| addr_o | output | ADDR_W | Current burst address |
| last_o | output | 1 | High on the fourth beat |

## Verification
The bench builds the block with `ADDR_W` = 8 and `SEQ_BITS` = 2, so the sequenced field is the real two-bit case. It sweeps all four start values in both orderings under four distinct upper-bit patterns, including all ones. That sweep covers every row of both ordering tables, the wrap taken after the fourth beat, and the flag position for each start. Every advance is driven with the opposite mode level, and loads are issued together with an advance, so mode capture and load priority are exercised on every burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR      = 1'b0,
      ORD_INTERLEAVED = 1'b1
   } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
   parameter int SEQ_BITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic                adv_i,
   output logic [SEQ_BITS-1:0] cnt_o,
   output logic                last_o
);
   localparam logic [SEQ_BITS-1:0] CNT_MAX = {SEQ_BITS{1'b1}};

   logic [SEQ_BITS-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= '0;
      else if (adv_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign last_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  order_e            order_i,
   output logic [ADDR_W-1:0] base_o,
   output order_e            order_o
);
   logic [ADDR_W-1:0] base_q;
   order_e            order_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         order_q <= ORD_INTERLEAVED;
      end else if (load_i) begin
         base_q  <= load_addr_i;
         order_q <= order_i;
      end
   end

   assign base_o  = base_q;
   assign order_o = order_q;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int SEQ_BITS = 2
) (
   input  logic [SEQ_BITS-1:0] start_i,
   input  logic [SEQ_BITS-1:0] beat_i,
   input  order_e              order_i,
   output logic [SEQ_BITS-1:0] low_o
);
   logic [SEQ_BITS-1:0] ilv;
   logic [SEQ_BITS-1:0] lin;

   for (genvar b = 0; b < SEQ_BITS; b++) begin : g_ilv
      assign ilv[b] = start_i[b] ^ beat_i[b];
   end

   assign lin = start_i + beat_i;

   always_comb begin
      unique case (order_i)
         ORD_LINEAR:      low_o = lin;
         ORD_INTERLEAVED: low_o = ilv;
         default:         low_o = ilv;
      endcase
   end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int SEQ_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr_i,
   input  logic              adv_i,
   input  logic              mode_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              last_o
);
   localparam int UP_W = ADDR_W - SEQ_BITS;

   initial begin
      if (SEQ_BITS < 1) $error("SEQ_BITS must be at least 1");
      if (UP_W < 1)     $error("ADDR_W must exceed SEQ_BITS");
   end

   logic [ADDR_W-1:0]   base;
   order_e              order_q;
   logic [SEQ_BITS-1:0] beat;
   logic [SEQ_BITS-1:0] low;

   burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_addr_i(load_addr_i),
      .order_i    (order_e'(mode_i)),
      .base_o     (base),
      .order_o    (order_q)
   );

   burst_beat_ctr #(.SEQ_BITS(SEQ_BITS)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(load_i),
      .adv_i (adv_i),
      .cnt_o (beat),
      .last_o(last_o)
   );

   burst_order_map #(.SEQ_BITS(SEQ_BITS)) u_map (
      .start_i(base[SEQ_BITS-1:0]),
      .beat_i (beat),
      .order_i(order_q),
      .low_o  (low)
   );

   assign addr_o = {base[ADDR_W-1:SEQ_BITS], low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W   = 20,
   parameter int SEQ_BITS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              load_i,
   input logic [ADDR_W-1:0] load_addr_i,
   input logic              adv_i,
   input logic              mode_i,
   input logic [ADDR_W-1:0] addr_o,
   input logic              last_o
);
   logic [ADDR_W-1:0]   sh_start;
   logic                sh_mode;
   logic [SEQ_BITS-1:0] sh_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_start <= '0;
         sh_mode  <= 1'b1;
         sh_cnt   <= '0;
      end else if (load_i) begin
         sh_start <= load_addr_i;
         sh_mode  <= mode_i;
         sh_cnt   <= '0;
      end else if (adv_i) begin
         sh_cnt   <= sh_cnt + 1'b1;
      end
   end

   // R2
   load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (addr_o == $past(load_addr_i)) && !last_o);

   // R3
   interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sh_mode |-> addr_o[SEQ_BITS-1:0] == (sh_start[SEQ_BITS-1:0] ^ sh_cnt));

   // R4
   linear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sh_mode |-> addr_o[SEQ_BITS-1:0] == SEQ_BITS'(sh_start[SEQ_BITS-1:0] + sh_cnt));

   // R5
   upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(addr_o[ADDR_W-1:SEQ_BITS]));

   // R8
   last_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o == (sh_cnt == {SEQ_BITS{1'b1}}));

   // R9
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_o && adv_i && !load_i) |=> addr_o == sh_start);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(addr_o) && $stable(last_o));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .SEQ_BITS(SEQ_BITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .load_addr_i(load_addr_i),
   .adv_i      (adv_i),
   .mode_i     (mode_i),
   .addr_o     (addr_o),
   .last_o     (last_o)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
   localparam int PERIOD = 10;
   localparam int AW     = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] load_addr_i = '0;
   logic          adv_i = 1'b0;
   logic          mode_i = 1'b1;
   logic [AW-1:0] addr_o;
   logic          last_o;

   int checks = 0;
   int fails  = 0;

   always #(PERIOD/2) clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .SEQ_BITS(2)) u_burst_addr_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_addr_i(load_addr_i),
      .adv_i      (adv_i),
      .mode_i     (mode_i),
      .addr_o     (addr_o),
      .last_o     (last_o)
   );

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic ld, input logic [AW-1:0] a, input logic av, input logic m);
      load_i      = ld;
      load_addr_i = a;
      adv_i       = av;
      mode_i      = m;
      @(posedge clk);
      #(PERIOD/4);
   endtask

   function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input int k, input logic m);
      logic [1:0] lo;
      lo = m ? (s[1:0] ^ 2'(k % 4)) : 2'((s[1:0] + k) % 4);
      return {s[AW-1:2], lo};
   endfunction

   initial begin
      #(PERIOD * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks + 1);
      $finish;
   end

   initial begin
      // R1: reset state
      cyc(1'b0, 8'h00, 1'b0, 1'b1);
      cyc(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R1 addr in reset", addr_o, '0);
      chk("R1 last in reset", {7'b0, last_o}, '0);
      rst_n = 1'b1;
      cyc(1'b0, 8'h00, 1'b0, 1'b1);
      chk("R1 addr after reset", addr_o, '0);
      chk("R1 last after reset", {7'b0, last_o}, '0);

      for (int up = 0; up < 64; up += 21) begin
         for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
               logic [AW-1:0] start;
               start = AW'((up << 2) | s);
               // R7: load issued together with an advance
               cyc(1'b1, start, 1'b1, 1'(m));
               chk("R2/R7 load start", addr_o, start);
               chk("R2/R7 last after load", {7'b0, last_o}, '0);
               for (int k = 1; k <= 5; k++) begin
                  // R6: mode input driven opposite during advances
                  cyc(1'b0, ~start, 1'b1, ~1'(m));
                  chk(m ? "R3/R5/R6/R9 interleaved beat" : "R4/R5/R6/R9 linear beat",
                      addr_o, expect_addr(start, k, 1'(m)));
                  chk("R8 last flag", {7'b0, last_o}, {7'b0, 1'((k % 4) == 3)});
               end
               // R10: idle hold on beat 1
               cyc(1'b0, ~start, 1'b0, ~1'(m));
               chk("R10 hold addr", addr_o, expect_addr(start, 1, 1'(m)));
               chk("R10 hold last", {7'b0, last_o}, '0);
            end
         end
      end

      // R7: load on the fourth beat together with advance restarts count
      cyc(1'b1, 8'hA6, 1'b0, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R8 last on fourth linear beat", {7'b0, last_o}, 8'h01);
      chk("R4 fourth linear beat", addr_o, 8'hA5);
      cyc(1'b1, 8'h3F, 1'b1, 1'b1);
      chk("R7 load beats advance", addr_o, 8'h3F);
      chk("R7 last cleared", {7'b0, last_o}, '0);
      cyc(1'b0, 8'h00, 1'b1, 1'b0);
      chk("R7 count restarted", addr_o, 8'h3E);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule